// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This unit resolves the indexed addressing mode of an 8-bit processor with a 16-bit address space. A start pulse hands it the postbyte of an instruction, a snapshot of the four 16-bit pointer registers, the two 8-bit accumulators and the address of the byte that follows the postbyte. From these it decodes the addressing form, fetches up to two offset bytes from memory, forms the effective address and, for the indirect forms, reads a 16-bit pointer from that address. The result is the final address that the instruction will use.

Along with the address it reports how many bytes after the postbyte belong to the operand and how many extra bus cycles the form costs the instruction. It also reports the new value for the chosen pointer when the form steps that pointer up or down, and whether the postbyte encodes no valid form. The register file lives outside the unit and applies the write-back itself. Every memory read uses a request/acknowledge pair. A read is taken on the clock edge where both are high, and the byte is carried on `mem_rdata` in that same cycle.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset, `done` and `mem_req` are low until a start pulse is accepted.
- R2: Postbyte bit 7 selects the form. When it is 0, the pointer register is chosen by bits 6:5 (0=X, 1=Y, 2=U, 3=S). Bits 4:0 are a two's-complement offset from -16 to +15, added to that pointer. The form costs 1 extra cycle and has 0 operand bytes.
- R3: With bit 7 set, the form is the postbyte AND 0x9F, and bit 4 marks an indirect form. The costs are, with the indirect cost in brackets:
  - 0x84, pointer with no offset: 0 (3).
  - 0x88, signed 8-bit operand offset: 1 (4).
  - 0x89, 16-bit operand offset: 4 (7).
  - 0x86, sign-extended accumulator A: 1 (4).
  - 0x85, sign-extended accumulator B: 1 (4).
  - 0x8B, the 16-bit value {A,B}: 4 (7).
- R4: Forms 0x80 and 0x81 use the pointer itself as the address and step it up by 1 and by 2. They cost 2 and 3 cycles. Forms 0x82 and 0x83 step the pointer down by 1 and by 2, and use the stepped value as the address. They cost 2 and 3 cycles. On `done`, these four forms raise `wb_en`, with `wb_sel` equal to bits 6:5 and `wb_value` equal to the stepped pointer. No other form raises `wb_en`.
- R5: Forms 0x8C and 0x8D add a signed 8-bit or a 16-bit operand to the address that follows the last operand byte, which is `pc_next` plus the operand byte count. They cost 1 (indirect 4) and 5 (indirect 8) cycles.
- R6: An indirect form first reads the high byte at the computed address and then the low byte at that address plus 1. The result is the 16-bit pointer formed from these two bytes. Only the step-by-2 forms may be indirect, at a cost of 6. Form 0x9F takes a 16-bit operand as the address to read, costs 5, and ignores bits 6:5.
- R7: Operand bytes are read from `pc_next` and then from `pc_next`+1, high byte first. `operand_bytes` reports 0, 1 or 2.
- R8: The postbytes that decode, after the AND with 0x9F, to 0x87, 0x8A, 0x8E, 0x8F, 0x90, 0x92, 0x97, 0x9A or 0x9E are illegal. For them `illegal` is raised and no memory read is made. `ea`, `operand_bytes` and `extra_cycles` are 0 and `wb_en` is low.
- R9: `done` is a single-cycle pulse. Counting from the edge that accepts start, it rises after 2 + k·(n + 2i) clock edges. Here n is the operand byte count, i is 1 for indirect forms and 0 otherwise, and each read is acknowledged k clock edges after its request rises. A pending request holds `mem_addr` stable until it is acknowledged.
- R10: A start pulse while a resolution is in progress is ignored. It does not change the result of that resolution and does not produce a second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving `postbyte` (accepted when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| ptr_x | input | 16 | Pointer register X |
| ptr_y | input | 16 | Pointer register Y |
| ptr_u | input | 16 | Pointer register U |
| ptr_s | input | 16 | Pointer register S |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| pc_next | input | 16 | Address of the byte after the postbyte |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read acknowledge, byte valid this cycle |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| operand_bytes | output | 2 | Bytes consumed after the postbyte |
| extra_cycles | output | 4 | Extra cycle cost of the form |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to write back (0=X,1=Y,2=U,3=S) |
| wb_value | output | 16 | Stepped pointer value |
| illegal | output | 1 | Postbyte encodes no valid form |

## Verification
The result of each form is due a fixed number of edges after start: 2 + k·(n + 2i). The bench controls k through its memory responder, which waits a set number of cycles before each acknowledge. The bench model computes that edge count in advance for every postbyte. On each falling edge it requires `done` to be high at exactly that count and low at every other count, up to six edges past it. The result fields are checked in that one cycle. Each read address is compared with the expected address in the cycle it is acknowledged.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int CYC_W   = 4;
  localparam int NB_W    = 2;
  localparam int SEL_W   = 2;
  localparam int SHORT_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_OPND, ST_CALC, ST_IND} st_e;
  typedef enum logic [1:0] {BASE_PTR, BASE_PC, BASE_NONE} base_e;
  typedef enum logic [2:0] {OFS_NONE, OFS_SHORT, OFS_OPND, OFS_ACCA, OFS_ACCB, OFS_ACCD} ofs_e;

  typedef struct packed {
    logic              legal;
    logic              indirect;
    logic [NB_W-1:0]   nbytes;
    logic [CYC_W-1:0]  cycles;
    base_e             base;
    ofs_e              ofs;
    logic              post_inc;
    logic              pre_dec;
    logic              step2;
  } mode_t;

  function automatic logic [ADDR_W-1:0] sext5(input logic [SHORT_W-1:0] v);
    return {{(ADDR_W-SHORT_W){v[SHORT_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] sext8(input logic [DATA_W-1:0] v);
    return {{(ADDR_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  // Table of forms: cost pairs are (direct, indirect).
  function automatic mode_t decode_postbyte(input logic [DATA_W-1:0] pb);
    mode_t m;
    logic  ind;
    m     = '0;
    ind   = pb[4];
    if (!pb[7]) begin
      m.legal  = 1'b1;
      m.ofs    = OFS_SHORT;
      m.cycles = 4'd1;
    end else begin
      m.legal    = 1'b1;
      m.indirect = ind;
      case (pb[3:0])
        4'h4: m.cycles = ind ? 4'd3 : 4'd0;
        4'h8: begin m.ofs = OFS_OPND; m.nbytes = 2'd1; m.cycles = ind ? 4'd4 : 4'd1; end
        4'h9: begin m.ofs = OFS_OPND; m.nbytes = 2'd2; m.cycles = ind ? 4'd7 : 4'd4; end
        4'h6: begin m.ofs = OFS_ACCA; m.cycles = ind ? 4'd4 : 4'd1; end
        4'h5: begin m.ofs = OFS_ACCB; m.cycles = ind ? 4'd4 : 4'd1; end
        4'hB: begin m.ofs = OFS_ACCD; m.cycles = ind ? 4'd7 : 4'd4; end
        4'h0: begin m.post_inc = 1'b1; m.cycles = 4'd2; m.legal = !ind; end
        4'h1: begin m.post_inc = 1'b1; m.step2 = 1'b1; m.cycles = ind ? 4'd6 : 4'd3; end
        4'h2: begin m.pre_dec = 1'b1; m.cycles = 4'd2; m.legal = !ind; end
        4'h3: begin m.pre_dec = 1'b1; m.step2 = 1'b1; m.cycles = ind ? 4'd6 : 4'd3; end
        4'hC: begin m.base = BASE_PC; m.ofs = OFS_OPND; m.nbytes = 2'd1; m.cycles = ind ? 4'd4 : 4'd1; end
        4'hD: begin m.base = BASE_PC; m.ofs = OFS_OPND; m.nbytes = 2'd2; m.cycles = ind ? 4'd8 : 4'd5; end
        4'hF: begin m.base = BASE_NONE; m.ofs = OFS_OPND; m.nbytes = 2'd2; m.cycles = 4'd5; m.legal = ind; end
        default: m.legal = 1'b0;
      endcase
    end
    if (!m.legal) m = '0;
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] offset_value(
      input ofs_e               ofs,
      input logic [NB_W-1:0]    nbytes,
      input logic [SHORT_W-1:0] short_ofs,
      input logic [DATA_W-1:0]  a,
      input logic [DATA_W-1:0]  b,
      input logic [ADDR_W-1:0]  opnd);
    case (ofs)
      OFS_SHORT: return sext5(short_ofs);
      OFS_OPND:  return (nbytes == 2'd1) ? sext8(opnd[DATA_W-1:0]) : opnd;
      OFS_ACCA:  return sext8(a);
      OFS_ACCB:  return sext8(b);
      OFS_ACCD:  return {a, b};
      default:   return '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] base_value(
      input base_e              base,
      input logic [NB_W-1:0]    nbytes,
      input logic [ADDR_W-1:0]  ptr,
      input logic [ADDR_W-1:0]  pcn);
    case (base)
      BASE_PTR: return ptr;
      BASE_PC:  return pcn + {{(ADDR_W-NB_W){1'b0}}, nbytes};
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
  import idx_ea_pkg::*;
(
  input  logic [DATA_W-1:0] pb,
  output mode_t             mode
);

  always_comb begin
    mode = decode_postbyte(pb);
    // R3: every legal form reads at most two operand bytes and costs at most 8
    if (mode.legal) begin
      assert_decode_sane_R3: assert (mode.nbytes <= 2'd2 && mode.cycles <= 4'd8
                                     && !(mode.post_inc && mode.pre_dec)
                                     && (!mode.indirect || pb[4]))
        else $error("decode table out of range");
    end
  end

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
(
  input  logic               legal,
  input  base_e              base,
  input  ofs_e               ofs,
  input  logic [NB_W-1:0]    nbytes,
  input  logic               post_inc,
  input  logic               pre_dec,
  input  logic               step2,
  input  logic [SHORT_W-1:0] short_ofs,
  input  logic [ADDR_W-1:0]  ptr,
  input  logic [ADDR_W-1:0]  pcn,
  input  logic [DATA_W-1:0]  acc_a,
  input  logic [DATA_W-1:0]  acc_b,
  input  logic [ADDR_W-1:0]  opnd,
  output logic [ADDR_W-1:0]  ea,
  output logic               wb_en,
  output logic [ADDR_W-1:0]  wb_value
);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    step = step2 ? ADDR_W'(2) : ADDR_W'(1);
    sum  = base_value(base, nbytes, ptr, pcn)
         + offset_value(ofs, nbytes, short_ofs, acc_a, acc_b, opnd);
    if (pre_dec) begin
      ea       = ptr - step;
      wb_value = ptr - step;
    end else if (post_inc) begin
      ea       = ptr;
      wb_value = ptr + step;
    end else begin
      ea       = sum;
      wb_value = ptr;
    end
    wb_en = legal && (post_inc || pre_dec);
  end

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DATA_W-1:0]   postbyte,
  input  logic [ADDR_W-1:0]   ptr_x,
  input  logic [ADDR_W-1:0]   ptr_y,
  input  logic [ADDR_W-1:0]   ptr_u,
  input  logic [ADDR_W-1:0]   ptr_s,
  input  logic [DATA_W-1:0]   acc_a,
  input  logic [DATA_W-1:0]   acc_b,
  input  logic [ADDR_W-1:0]   pc_next,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                done,
  output logic [ADDR_W-1:0]   ea,
  output logic [NB_W-1:0]     operand_bytes,
  output logic [CYC_W-1:0]    extra_cycles,
  output logic                wb_en,
  output logic [SEL_W-1:0]    wb_sel,
  output logic [ADDR_W-1:0]   wb_value,
  output logic                illegal
);

  st_e               st;
  logic [DATA_W-1:0] pb_q;
  logic [ADDR_W-1:0] ptr_q, pc_q, opnd_q, ea_q;
  logic [DATA_W-1:0] a_q, b_q, ind_hi_q;
  logic              idx_q;

  logic [DATA_W-1:0] dec_pb;
  mode_t             mode;
  logic [ADDR_W-1:0] calc_ea, calc_wb;
  logic              calc_wb_en;
  logic [ADDR_W-1:0] sel_ptr;

  // named internal events
  logic              accept_start;
  logic              fetch_fire;
  logic              last_opnd;

  assign dec_pb       = (st == ST_IDLE) ? postbyte : pb_q;
  assign accept_start = start && (st == ST_IDLE);
  assign fetch_fire   = mem_req && mem_ack;
  assign last_opnd    = idx_q || (mode.nbytes == 2'd1);

  always_comb begin
    case (postbyte[6:5])
      2'd0:    sel_ptr = ptr_x;
      2'd1:    sel_ptr = ptr_y;
      2'd2:    sel_ptr = ptr_u;
      default: sel_ptr = ptr_s;
    endcase
  end

  idx_pb_decode u_dec (
    .pb   (dec_pb),
    .mode (mode)
  );

  idx_ea_calc u_calc (
    .legal     (mode.legal),
    .base      (mode.base),
    .ofs       (mode.ofs),
    .nbytes    (mode.nbytes),
    .post_inc  (mode.post_inc),
    .pre_dec   (mode.pre_dec),
    .step2     (mode.step2),
    .short_ofs (pb_q[SHORT_W-1:0]),
    .ptr       (ptr_q),
    .pcn       (pc_q),
    .acc_a     (a_q),
    .acc_b     (b_q),
    .opnd      (opnd_q),
    .ea        (calc_ea),
    .wb_en     (calc_wb_en),
    .wb_value  (calc_wb)
  );

  assign mem_req  = (st == ST_OPND) || (st == ST_IND);
  assign mem_addr = ((st == ST_IND) ? ea_q : pc_q) + {{(ADDR_W-1){1'b0}}, idx_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      pb_q          <= '0;
      ptr_q         <= '0;
      pc_q          <= '0;
      a_q           <= '0;
      b_q           <= '0;
      opnd_q        <= '0;
      ea_q          <= '0;
      ind_hi_q      <= '0;
      idx_q         <= 1'b0;
      done          <= 1'b0;
      ea            <= '0;
      operand_bytes <= '0;
      extra_cycles  <= '0;
      wb_en         <= 1'b0;
      wb_sel        <= '0;
      wb_value      <= '0;
      illegal       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept_start) begin
            pb_q   <= postbyte;
            ptr_q  <= sel_ptr;
            pc_q   <= pc_next;
            a_q    <= acc_a;
            b_q    <= acc_b;
            opnd_q <= '0;
            idx_q  <= 1'b0;
            st     <= (mode.nbytes != 2'd0) ? ST_OPND : ST_CALC;
          end
        end
        ST_OPND: begin
          if (fetch_fire) begin
            opnd_q <= {opnd_q[DATA_W-1:0], mem_rdata};
            if (last_opnd) begin
              idx_q <= 1'b0;
              st    <= ST_CALC;
            end else begin
              idx_q <= 1'b1;
            end
          end
        end
        ST_CALC: begin
          operand_bytes <= mode.nbytes;
          extra_cycles  <= mode.cycles;
          wb_en         <= calc_wb_en;
          wb_sel        <= pb_q[6:5];
          wb_value      <= calc_wb;
          illegal       <= !mode.legal;
          if (mode.indirect) begin
            ea_q  <= calc_ea;
            idx_q <= 1'b0;
            st    <= ST_IND;
          end else begin
            ea   <= mode.legal ? calc_ea : '0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: begin
          if (fetch_fire) begin
            if (!idx_q) begin
              ind_hi_q <= mem_rdata;
              idx_q    <= 1'b1;
            end else begin
              ea    <= {ind_hi_q, mem_rdata};
              idx_q <= 1'b0;
              done  <= 1'b1;
              st    <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R9: result strobe lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a pending read keeps its address until acknowledged
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6: a result follows either the compute step or an accepted pointer byte
  assert_done_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == ST_CALC || ($past(st) == ST_IND && $past(fetch_fire))));

  // R8: illegal postbytes leave no address, cost or write-back behind
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!wb_en && ea == '0 && operand_bytes == '0 && extra_cycles == '0));

  // R4: write-back moves the captured pointer by one or two
  assert_wb_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en) |-> (wb_value == ptr_q + 16'd1 || wb_value == ptr_q + 16'd2 ||
                         wb_value == ptr_q - 16'd1 || wb_value == ptr_q - 16'd2));

endmodule

// File: tb/tb_idx_ea_unit.sv
module tb_idx_ea_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [15:0] rx = '0, ry = '0, ru = '0, rs = '0, pcn = '0;
  logic [7:0]  ra = '0, rb = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done, wb_en, illegal;
  logic [15:0] ea, wb_value;
  logic [1:0]  operand_bytes, wb_sel;
  logic [3:0]  extra_cycles;

  always #2 clk = ~clk;   // 250 MHz

  idx_ea_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .ptr_x(rx), .ptr_y(ry), .ptr_u(ru), .ptr_s(rs),
    .acc_a(ra), .acc_b(rb), .pc_next(pcn),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .ea(ea), .operand_bytes(operand_bytes), .extra_cycles(extra_cycles),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value), .illegal(illegal)
  );

  int errors = 0;
  int checks = 0;
  int wait_n = 0;
  int wcnt   = 0;
  int exp_addr[$];
  int exp_ea, exp_nb, exp_cyc, exp_wbv, exp_wbsel, exp_E;
  bit exp_wbe, exp_ill;
  string tag;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h96;
  endfunction

  function automatic int sx8(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // memory responder: acknowledges after wait_n idle falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= wait_n) begin
        mem_ack   = 1'b1;
        mem_rdata = mbyte(mem_addr);
        wcnt      = 0;
        if (exp_addr.size() == 0) begin
          check(1'b0, "R8", "unexpected read", int'(mem_addr), -1);
        end else begin
          check(int'(mem_addr) == exp_addr[0], "R7", "read address",
                int'(mem_addr), exp_addr[0]);
          void'(exp_addr.pop_front());
        end
      end else begin
        mem_ack = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ack = 1'b0;
      wcnt = 0;
    end
  end

  // behavioural reference for one postbyte
  task automatic ref_model(input logic [7:0] pb);
    int ptr, code, o5, o8, w16, nb, base_pc, p;
    bit ind;
    case (pb[6:5])
      2'd0: ptr = rx;
      2'd1: ptr = ry;
      2'd2: ptr = ru;
      default: ptr = rs;
    endcase
    o8  = sx8(mbyte(pcn));
    w16 = mbyte(pcn) * 256 + mbyte(16'(pcn + 16'd1));
    nb = 0; ind = 0; exp_wbe = 0; exp_wbv = 0; exp_ill = 0; exp_cyc = 0; exp_ea = 0;
    exp_wbsel = pb[6:5];
    tag = "R3";
    if (pb < 8'h80) begin
      o5 = pb % 32;
      if (o5 >= 16) o5 -= 32;
      exp_ea = ptr + o5; exp_cyc = 1; tag = "R2";
    end else begin
      code = pb & 8'h9F;
      ind  = (code >= 8'h90);
      case (code)
        8'h84, 8'h94: begin exp_ea = ptr; exp_cyc = ind ? 3 : 0; end
        8'h88, 8'h98: begin nb = 1; exp_ea = ptr + o8; exp_cyc = ind ? 4 : 1; end
        8'h89, 8'h99: begin nb = 2; exp_ea = ptr + w16; exp_cyc = ind ? 7 : 4; end
        8'h86, 8'h96: begin exp_ea = ptr + sx8(ra); exp_cyc = ind ? 4 : 1; end
        8'h85, 8'h95: begin exp_ea = ptr + sx8(rb); exp_cyc = ind ? 4 : 1; end
        8'h8B, 8'h9B: begin exp_ea = ptr + ra * 256 + rb; exp_cyc = ind ? 7 : 4; end
        8'h80: begin exp_ea = ptr; exp_wbe = 1; exp_wbv = ptr + 1; exp_cyc = 2; tag = "R4"; end
        8'h81, 8'h91: begin exp_ea = ptr; exp_wbe = 1; exp_wbv = ptr + 2; exp_cyc = ind ? 6 : 3; tag = "R4"; end
        8'h82: begin exp_ea = ptr - 1; exp_wbe = 1; exp_wbv = ptr - 1; exp_cyc = 2; tag = "R4"; end
        8'h83, 8'h93: begin exp_ea = ptr - 2; exp_wbe = 1; exp_wbv = ptr - 2; exp_cyc = ind ? 6 : 3; tag = "R4"; end
        8'h8C, 8'h9C: begin nb = 1; base_pc = pcn + 1; exp_ea = base_pc + o8; exp_cyc = ind ? 4 : 1; tag = "R5"; end
        8'h8D, 8'h9D: begin nb = 2; base_pc = pcn + 2; exp_ea = base_pc + w16; exp_cyc = ind ? 8 : 5; tag = "R5"; end
        8'h9F: begin nb = 2; exp_ea = w16; exp_cyc = 5; end
        default: begin exp_ill = 1; ind = 0; tag = "R8"; end
      endcase
      if (ind && !exp_ill) tag = "R6";
    end
    exp_ea  = exp_ea & 16'hFFFF;
    exp_wbv = exp_wbv & 16'hFFFF;
    for (int i = 0; i < nb; i++) exp_addr.push_back((pcn + i) & 16'hFFFF);
    if (ind) begin
      p = exp_ea;
      exp_addr.push_back(p);
      exp_addr.push_back((p + 1) & 16'hFFFF);
      exp_ea = mbyte(16'(p)) * 256 + mbyte(16'(p + 1));
    end
    exp_nb = nb;
    exp_E  = 2 + (wait_n + 1) * (nb + (ind ? 2 : 0));
  endtask

  task automatic run_op(input logic [7:0] pb, input bit poke);
    string tt;
    ref_model(pb);
    @(negedge clk);
    postbyte = pb;
    start    = 1'b1;
    for (int k = 1; k <= exp_E + 6; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (poke) postbyte = 8'h84; else start = 1'b0;
      end
      if (k == 2) start = 1'b0;
      tt = poke ? "R10" : "R9";
      check(done == (k == exp_E), tt, "done timing", int'(done), int'(k == exp_E));
      if (k == exp_E && done) begin
        check(int'(ea) == exp_ea, tag, "ea", int'(ea), exp_ea);
        check(int'(operand_bytes) == exp_nb, "R7", "operand_bytes", int'(operand_bytes), exp_nb);
        check(int'(extra_cycles) == exp_cyc, tag, "extra_cycles", int'(extra_cycles), exp_cyc);
        check(illegal == exp_ill, "R8", "illegal", int'(illegal), int'(exp_ill));
        check(wb_en == exp_wbe, "R4", "wb_en", int'(wb_en), int'(exp_wbe));
        if (exp_wbe) begin
          check(int'(wb_value) == exp_wbv, "R4", "wb_value", int'(wb_value), exp_wbv);
          check(int'(wb_sel) == exp_wbsel, "R4", "wb_sel", int'(wb_sel), exp_wbsel);
        end
      end
    end
    check(exp_addr.size() == 0, "R7", "reads outstanding", exp_addr.size(), 0);
    exp_addr.delete();
  endtask

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);

    // every postbyte, varied register contents and acknowledge latency
    for (int p = 0; p < 256; p++) begin
      rx  = 16'(16'h1234 + p * 97);
      ry  = 16'(16'hA0F1 + p * 211);
      ru  = 16'(16'h7FFE - p * 53);
      rs  = 16'(16'h0100 + p * 7);
      ra  = 8'(p * 13);
      rb  = 8'(~p);
      pcn = 16'(16'h8000 + p * 5);
      wait_n = p % 3;
      run_op(8'(p), 1'b0);
    end

    // boundary cases: wrap-around of steps, offsets and operand fetch
    wait_n = 0;
    rs = 16'h0000; run_op(8'hE3, 1'b0);          // R4 pre-dec by 2 on S wraps
    rx = 16'hFFFF; run_op(8'h81, 1'b0);          // R4 post-inc by 2 wraps
    rx = 16'h0005; run_op(8'h10, 1'b0);          // R2 offset -16
    rx = 16'h0005; run_op(8'h0F, 1'b0);          // R2 offset +15
    pcn = 16'hFFFF; run_op(8'h8D, 1'b0);         // R5 operand bytes wrap past top
    pcn = 16'hFFFE; wait_n = 1; run_op(8'hBF, 1'b0); // R6 extended indirect, bits 6:5 ignored
    ra = 8'h80; rb = 8'h00; ru = 16'h0000; run_op(8'hC6, 1'b0); // R3 A = -128

    // R10: second start during a resolution is ignored
    wait_n = 1; pcn = 16'h4000; ry = 16'h2222;
    run_op(8'hA9, 1'b1);
    wait_n = 0;
    run_op(8'h8A, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule